// File: doc/BRIEF.md
# Transmit collision statistics counter unit

This unit sits beside the transmit engine of an Ethernet MAC and turns its per-frame event strobes into statistics. The engine tells it when a new frame begins, when a retry attempt begins, when each byte time passes, when a collision is seen, when the frame finishes, and when it is aborted by a FIFO underflow. It also reports deferral events, with their cause, and carrier-sense loss. From this history the unit sorts every frame into one of four outcomes: no collision, a single collision, multiple collisions or an excessive-collision abort. It also flags each collision that comes too late into its attempt, using a threshold that depends on link speed.

Eight saturating counters hold the results. Software reads them over a plain address and read-strobe port, and each read clears the counter it returns. The collision counters only run in half-duplex mode with transmit enabled. The carrier-sense counter only runs in full-duplex mode with transmit enabled.

Top module: `txstat_unit`

## Requirements
- R1: A frame that completes (`frm_done`) after exactly one collision in its history adds 1 to the single-collision counter (address 0).
- R2: A frame that completes after 2 to 15 collisions adds 1 to the multiple-collision counter (address 1). A frame that completes with no collision changes neither counter.
- R3: The 16th collision of a frame counts as an excessive-collision abort (address 2), and the frame history is closed. Address 8 reads the same counter as the transmit error total, and a read there clears it.
- R4: A collision is late (address 3) when its byte offset in the current attempt is above 64 with `speed_gig`=0, or above 512 with `speed_gig`=1. The offset counts `byte_tick` cycles since the last `frm_start` or `retry_start`.
- R5: The single, multiple, excessive, late and total collision counters change only while `full_duplex`=0 and `tx_enable`=1.
- R6: The total collision counter (address 4) adds 1 for every `col_det` strobe.
- R7: A `defer_evt` with `tx_enable`=1 adds 1 to the defer counter (address 5) for cause codes 0 (busy medium), 1 (inter-packet gap), 2 (pause received) and 3 (link down). It does not count when the cause is 1 and `defer_stream`=1.
- R8: `crs_lost` adds 1 to the carrier-sense counter (address 6) only while `full_duplex`=1 and `tx_enable`=1.
- R9: `uf_abort` adds 1 to the underflow counter (address 7) and closes the frame history. It does not add to the single or multiple counters.
- R10: Every counter stops at all ones instead of wrapping.
- R11: With `rd_en`=1, `rd_data` shows the addressed counter in the same cycle, and the counter is cleared at the next clock edge. An event for that counter in the same cycle leaves a value of 1. Unmapped addresses read 0, and `rd_data` is 0 while `rd_en`=0.
- R12: After reset every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_gig | input | 1 | 1 = gigabit link, 0 = 10/100 link |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_enable | input | 1 | Transmit enabled |
| frm_start | input | 1 | Strobe: first preamble byte of a new frame |
| retry_start | input | 1 | Strobe: first preamble byte of a retry attempt |
| byte_tick | input | 1 | One byte time elapsed |
| col_det | input | 1 | Strobe: collision detected |
| frm_done | input | 1 | Strobe: frame sent successfully |
| uf_abort | input | 1 | Strobe: frame aborted by FIFO underflow |
| defer_evt | input | 1 | Strobe: transmission deferred |
| defer_cause | input | 2 | Defer cause: 0 busy, 1 gap, 2 pause, 3 link down |
| defer_stream | input | 1 | The deferred send is a streaming transmit |
| crs_lost | input | 1 | Strobe: carrier sense missing during a transmission |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Counter address |
| rd_data | output | CNT_W | Addressed counter value |

## Verification
Frames are driven with 0, 1, 2, 15 and 16 collisions. These show where the single, multiple and excessive counts part and that the 16th collision closes the frame. Collision offsets of 64/65 at 10/100 speed and 512/513 at gigabit speed put the late threshold on each side of the boundary at both speeds. The same frames in full duplex, with transmit disabled, and ended by underflow show the gating and the underflow path. Directed sequences cover each defer cause with and without streaming, carrier loss in both duplex modes, saturation, a read that coincides with an event, the alias address and an unmapped address.

// File: rtl/txstat_pkg.sv
// Shared constants for the transmit statistics unit: counter indices,
// address map and the read-port width. Every counter has an index equal
// to its read address; one extra address aliases the excessive counter.
package txstat_pkg;
    localparam int NUM_CNT    = 8;
    localparam int ADDR_W     = 4;
    localparam int IDX_SINGLE = 0;
    localparam int IDX_MULTI  = 1;
    localparam int IDX_EXCESS = 2;
    localparam int IDX_LATE   = 3;
    localparam int IDX_TOTAL  = 4;
    localparam int IDX_DEFER  = 5;
    localparam int IDX_CARR   = 6;
    localparam int IDX_UFLOW  = 7;
    localparam int ADDR_TXERR = 8;

    typedef enum logic [1:0] {
        DEF_BUSY  = 2'd0,
        DEF_GAP   = 2'd1,
        DEF_PAUSE = 2'd2,
        DEF_LINK  = 2'd3
    } defer_cause_e;
endpackage

// File: rtl/txstat_byte_timer.sv
// Byte-time offset timer. It restarts at zero on every frame or retry
// start and counts byte ticks after that, stopping at its top value.
// It reports whether a collision at the current offset would be late.
// Assumes a start strobe and a byte tick in the same cycle mean start.
module txstat_byte_timer #(
    parameter int OFS_W     = 10,
    parameter int SLOW_LATE = 64,
    parameter int GIG_LATE  = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic byte_tick,
    input  logic speed_gig,
    output logic is_late
);
    localparam logic [OFS_W-1:0] OFS_MAX = '1;

    logic [OFS_W-1:0] ofs_q;

    // Offset register: cleared on each attempt start, held at its top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (restart) begin
            ofs_q <= '0;
        end else if (byte_tick && ofs_q != OFS_MAX) begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    // Late decision against the speed-dependent threshold.
    always_comb begin
        if (speed_gig) begin
            is_late = int'(ofs_q) > GIG_LATE;
        end else begin
            is_late = int'(ofs_q) > SLOW_LATE;
        end
    end
endmodule

// File: rtl/txstat_classifier.sv
// Per-frame collision history and event classifier. It counts the
// collisions of the current frame and, from that history and the
// engine strobes, raises one increment strobe per statistics counter.
// It assumes the engine never strobes a collision and a frame end in
// the same cycle. Duplex and enable gating are applied here.
module txstat_classifier
    import txstat_pkg::*;
#(
    parameter int MAX_COLL = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               full_duplex,
    input  logic               tx_enable,
    input  logic               frm_start,
    input  logic               col_det,
    input  logic               col_late,
    input  logic               frm_done,
    input  logic               uf_abort,
    input  logic               defer_evt,
    input  logic [1:0]         defer_cause,
    input  logic               defer_stream,
    input  logic               crs_lost,
    output logic [NUM_CNT-1:0] inc
);
    localparam int CW = $clog2(MAX_COLL + 1);
    localparam logic [CW-1:0] LAST_COLL = CW'(MAX_COLL - 1);

    logic [CW-1:0] coll_q;
    logic          hd_on;
    logic          fd_on;
    logic          last_hit;
    logic          defer_ok;

    assign hd_on    = !full_duplex && tx_enable;
    assign fd_on    = full_duplex && tx_enable;
    assign last_hit = col_det && (coll_q == LAST_COLL);

    // Collision history of the frame: reset on start, end or give-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q <= '0;
        end else if (frm_start || frm_done || uf_abort || last_hit) begin
            coll_q <= '0;
        end else if (col_det) begin
            coll_q <= coll_q + 1'b1;
        end
    end

    // Streaming sends waiting only for the gap are not deferrals.
    always_comb begin
        defer_ok = !(defer_cause == DEF_GAP && defer_stream);
    end

    // Increment strobes for each counter.
    always_comb begin
        inc             = '0;
        inc[IDX_SINGLE] = hd_on && frm_done && coll_q == CW'(1);
        inc[IDX_MULTI]  = hd_on && frm_done && coll_q > CW'(1);
        inc[IDX_EXCESS] = hd_on && last_hit;
        inc[IDX_LATE]   = hd_on && col_det && col_late;
        inc[IDX_TOTAL]  = hd_on && col_det;
        inc[IDX_DEFER]  = tx_enable && defer_evt && defer_ok;
        inc[IDX_CARR]   = fd_on && crs_lost;
        inc[IDX_UFLOW]  = uf_abort;
    end
endmodule

// File: rtl/txstat_sat_counter.sv
// One statistics counter: saturating increment, clear on read. A read
// in the same cycle as an increment leaves the counter at one.
module txstat_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count register with read-clear priority over saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= inc ? CNT_W'(1) : '0;
        end else if (inc && q != CNT_MAX) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/txstat_unit.sv
// Transmit collision statistics unit, top level. It ties together the
// byte-time timer, the frame classifier and one saturating counter per
// statistic, and exposes a combinational read port with clear-on-read.
// It assumes all strobes are single-cycle and synchronous to clk.
module txstat_unit
    import txstat_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int OFS_W     = 10,
    parameter int SLOW_LATE = 64,
    parameter int GIG_LATE  = 512,
    parameter int MAX_COLL  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_gig,
    input  logic              full_duplex,
    input  logic              tx_enable,
    input  logic              frm_start,
    input  logic              retry_start,
    input  logic              byte_tick,
    input  logic              col_det,
    input  logic              frm_done,
    input  logic              uf_abort,
    input  logic              defer_evt,
    input  logic [1:0]        defer_cause,
    input  logic              defer_stream,
    input  logic              crs_lost,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    logic                           col_late;
    logic [NUM_CNT-1:0]             inc_vec;
    logic [NUM_CNT-1:0]             clr_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;

    txstat_byte_timer #(
        .OFS_W    (OFS_W),
        .SLOW_LATE(SLOW_LATE),
        .GIG_LATE (GIG_LATE)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (frm_start || retry_start),
        .byte_tick(byte_tick),
        .speed_gig(speed_gig),
        .is_late  (col_late)
    );

    txstat_classifier #(
        .MAX_COLL(MAX_COLL)
    ) i_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_duplex (full_duplex),
        .tx_enable   (tx_enable),
        .frm_start   (frm_start),
        .col_det     (col_det),
        .col_late    (col_late),
        .frm_done    (frm_done),
        .uf_abort    (uf_abort),
        .defer_evt   (defer_evt),
        .defer_cause (defer_cause),
        .defer_stream(defer_stream),
        .crs_lost    (crs_lost),
        .inc         (inc_vec)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        // Clear decode: own address, plus the alias for the excessive one.
        always_comb begin
            clr_vec[g] = rd_en && (rd_addr == ADDR_W'(g));
            if (g == IDX_EXCESS) begin
                clr_vec[g] = clr_vec[g] || (rd_en && rd_addr == ADDR_W'(ADDR_TXERR));
            end
        end

        txstat_sat_counter #(
            .CNT_W(CNT_W)
        ) i_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc_vec[g]),
            .clr  (clr_vec[g]),
            .q    (cnt_q[g])
        );
    end

    // Read multiplexer: zero when idle or for unmapped addresses.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(ADDR_TXERR)) begin
                rd_data = cnt_q[IDX_EXCESS];
            end else if (int'(rd_addr) < NUM_CNT) begin
                rd_data = cnt_q[rd_addr[$clog2(NUM_CNT)-1:0]];
            end
        end
    end
endmodule

// File: rtl/txstat_checker.sv
// Assertion checker for txstat_unit, attached with bind below. It
// relates the classifier strobes, the read port and the counter state.
module txstat_checker
    import txstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          full_duplex,
    input logic                          tx_enable,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [NUM_CNT-1:0]            inc_vec,
    input logic [NUM_CNT-1:0]            clr_vec,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_HD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex || !tx_enable) |-> inc_vec[IDX_TOTAL:IDX_SINGLE] == '0); // R5

    AST_FD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex || !tx_enable) |-> !inc_vec[IDX_CARR]); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc_vec[IDX_SINGLE], inc_vec[IDX_MULTI], inc_vec[IDX_EXCESS], inc_vec[IDX_UFLOW]})); // R2

    AST_LATE_IS_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        inc_vec[IDX_LATE] |-> inc_vec[IDX_TOTAL]); // R6

    AST_ALIAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(ADDR_TXERR) && !inc_vec[IDX_EXCESS])
        |=> cnt_q[IDX_EXCESS] == '0); // R3

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == CNT_MAX && !clr_vec[g]) |=> cnt_q[g] == CNT_MAX); // R10

        AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == ADDR_W'(g)) |=> cnt_q[g] == CNT_W'($past(inc_vec[g]))); // R11

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!inc_vec[g] && !clr_vec[g]) |=> $stable(cnt_q[g])); // R11
    end
endmodule

bind txstat_unit txstat_checker #(.CNT_W(CNT_W)) i_txstat_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_duplex(full_duplex),
    .tx_enable  (tx_enable),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .inc_vec    (inc_vec),
    .clr_vec    (clr_vec),
    .cnt_q      (cnt_q)
);

// File: tb/test_txstat_unit.sv
// Bench for txstat_unit: a frame-scenario table walked by one loop,
// then directed tests. Counters are narrowed to 6 bits so that
// saturation is reachable.
module test_txstat_unit;
    localparam int W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_gig = 1'b0, full_duplex = 1'b0, tx_enable = 1'b1;
    logic frm_start = 1'b0, retry_start = 1'b0, byte_tick = 1'b0, col_det = 1'b0;
    logic frm_done = 1'b0, uf_abort = 1'b0, defer_evt = 1'b0, defer_stream = 1'b0;
    logic crs_lost = 1'b0, rd_en = 1'b0;
    logic [1:0] defer_cause = 2'd0;
    logic [3:0] rd_addr = 4'd0;
    logic [W-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txstat_unit #(.CNT_W(W)) i_txstat_unit (
        .clk(clk), .rst_n(rst_n), .speed_gig(speed_gig), .full_duplex(full_duplex),
        .tx_enable(tx_enable), .frm_start(frm_start), .retry_start(retry_start),
        .byte_tick(byte_tick), .col_det(col_det), .frm_done(frm_done),
        .uf_abort(uf_abort), .defer_evt(defer_evt), .defer_cause(defer_cause),
        .defer_stream(defer_stream), .crs_lost(crs_lost), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [4:0] ncol;
        logic [9:0] ofs;
        logic       gig;
        logic       fd;
        logic       en;
        logic       uf;
        logic [7:0] e_single;
        logic [7:0] e_multi;
        logic [7:0] e_exc;
        logic [7:0] e_late;
        logic [7:0] e_total;
        logic [7:0] e_uf;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{5'd0,  10'd10,  1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0,  8'd0}, // R2 none
        '{5'd1,  10'd10,  1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 8'd0, 8'd0, 8'd0,  8'd1,  8'd0}, // R1
        '{5'd2,  10'd10,  1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd1, 8'd0, 8'd0,  8'd2,  8'd0}, // R2
        '{5'd15, 10'd3,   1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd1, 8'd0, 8'd0,  8'd15, 8'd0}, // R2
        '{5'd16, 10'd3,   1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 8'd1, 8'd0,  8'd16, 8'd0}, // R3
        '{5'd1,  10'd64,  1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 8'd0, 8'd0, 8'd0,  8'd1,  8'd0}, // R4
        '{5'd1,  10'd65,  1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 8'd0, 8'd0, 8'd1,  8'd1,  8'd0}, // R4
        '{5'd1,  10'd65,  1'b1, 1'b0, 1'b1, 1'b0, 8'd1, 8'd0, 8'd0, 8'd0,  8'd1,  8'd0}, // R4
        '{5'd1,  10'd512, 1'b1, 1'b0, 1'b1, 1'b0, 8'd1, 8'd0, 8'd0, 8'd0,  8'd1,  8'd0}, // R4
        '{5'd1,  10'd513, 1'b1, 1'b0, 1'b1, 1'b0, 8'd1, 8'd0, 8'd0, 8'd1,  8'd1,  8'd0}, // R4
        '{5'd16, 10'd70,  1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 8'd1, 8'd16, 8'd16, 8'd0}, // R3 R4
        '{5'd2,  10'd70,  1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0,  8'd0}, // R5 fd
        '{5'd16, 10'd70,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0,  8'd0}, // R5 off
        '{5'd1,  10'd10,  1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0,  8'd1,  8'd1}, // R9
        '{5'd3,  10'd5,   1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0,  8'd3,  8'd1}  // R9 R6
    };

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Read one counter: data sampled before the clearing edge.
    task automatic rd(input int a, output int v);
        rd_en = 1'b1;
        rd_addr = 4'(a);
        #1 v = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        int v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            byte_tick = 1'b1;
            repeat (n) @(negedge clk);
            byte_tick = 1'b0;
        end
    endtask

    task automatic run_frame(input vec_t v);
        speed_gig = v.gig;
        full_duplex = v.fd;
        tx_enable = v.en;
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        for (int k = 0; k < int'(v.ncol); k++) begin
            ticks(int'(v.ofs));
            col_det = 1'b1;
            @(negedge clk);
            col_det = 1'b0;
            if (k < 15) begin
                retry_start = 1'b1;
                @(negedge clk);
                retry_start = 1'b0;
            end
        end
        if (v.ncol < 5'd16) begin
            if (v.uf) uf_abort = 1'b1;
            else frm_done = 1'b1;
            @(negedge clk);
            uf_abort = 1'b0;
            frm_done = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic defer_pulse(input logic [1:0] c, input logic s);
        defer_cause = c;
        defer_stream = s;
        defer_evt = 1'b1;
        @(negedge clk);
        defer_evt = 1'b0;
        defer_stream = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: all counters zero after reset.
        for (int a = 0; a < 8; a++) rd_check("R12 reset", a, 0);

        // Table walk of frame scenarios.
        for (int i = 0; i < NV; i++) begin
            run_frame(TBL[i]);
            tx_enable = 1'b1;
            full_duplex = 1'b0;
            rd_check("R1 single", 0, int'(TBL[i].e_single));
            rd_check("R2 multi", 1, int'(TBL[i].e_multi));
            rd_check("R3 excess", 2, int'(TBL[i].e_exc));
            rd_check("R4 late", 3, int'(TBL[i].e_late));
            rd_check("R6 total", 4, int'(TBL[i].e_total));
            rd_check("R9 uflow", 7, int'(TBL[i].e_uf));
        end

        // R7: each cause counts; streaming gap wait does not.
        defer_pulse(2'd0, 1'b0);
        defer_pulse(2'd1, 1'b0);
        defer_pulse(2'd2, 1'b0);
        defer_pulse(2'd3, 1'b0);
        rd_check("R7 four causes", 5, 4);
        defer_pulse(2'd1, 1'b1);
        rd_check("R7 streaming gap", 5, 0);
        defer_pulse(2'd0, 1'b1);
        defer_pulse(2'd2, 1'b1);
        rd_check("R7 streaming other", 5, 2);
        tx_enable = 1'b0;
        defer_pulse(2'd0, 1'b0);
        tx_enable = 1'b1;
        rd_check("R7 disabled", 5, 0);

        // R8: carrier loss counts only in full duplex with enable.
        crs_lost = 1'b1;
        @(negedge clk);
        crs_lost = 1'b0;
        rd_check("R8 half duplex", 6, 0);
        full_duplex = 1'b1;
        crs_lost = 1'b1;
        repeat (2) @(negedge clk);
        crs_lost = 1'b0;
        rd_check("R8 full duplex", 6, 2);
        tx_enable = 1'b0;
        crs_lost = 1'b1;
        @(negedge clk);
        crs_lost = 1'b0;
        tx_enable = 1'b1;
        full_duplex = 1'b0;
        rd_check("R8 disabled", 6, 0);

        // R10: saturation at all ones (6-bit counters here).
        defer_cause = 2'd0;
        defer_stream = 1'b0;
        defer_evt = 1'b1;
        repeat (70) @(negedge clk);
        defer_evt = 1'b0;
        rd_check("R10 saturate", 5, 63);

        // R11: read in the same cycle as an event leaves 1.
        defer_pulse(2'd0, 1'b0);
        defer_pulse(2'd0, 1'b0);
        defer_evt = 1'b1;
        begin
            int v;
            rd(5, v);
            check("R11 read value", v, 2);
        end
        defer_evt = 1'b0;
        rd_check("R11 event kept", 5, 1);

        // R11: unmapped address reads 0; idle port reads 0.
        rd_check("R11 unmapped", 15, 0);
        defer_pulse(2'd0, 1'b0);
        #1 check("R11 idle port", int'(rd_data), 0);
        rd_check("R11 idle kept", 5, 1);

        // R3: alias address returns and clears the excessive counter.
        run_frame(TBL[4]);
        rd_check("R3 alias read", 8, 1);
        rd_check("R3 alias cleared", 2, 0);

        finish_run();
    end
endmodule